// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus (I2C/SMBus style) in front of a 256-location by 8-bit memory. The memory is held in a register array. The block samples the bus clock and data lines with a fast system clock. It recognises Start and Stop conditions and answers only to a device-select byte that carries the fixed type code and matches its three strapped chip-enable pins. It drives the data line only by pulling it low, so a board pull-up and a wired-AND bus can be used.

A master writes one byte, or a burst of up to a page, after sending a word address. The write is committed only when the master sends Stop. A self-timed programming lockout then follows. While it runs, the device does not answer its select byte. Reads take several forms:
- a random read, which is a dummy write of the address followed by a repeated Start;
- a current-address read, which continues from an internal counter;
- a sequential burst, which keeps going while the master acknowledges.

A write-control input blocks all stores. A power-on reset input silences the block completely.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The device-select byte is accepted only if its bits [7:4] equal 4'b1011 and its bits [3:1] equal the chipSel pins. Bit 0 selects the direction: 1 means read and 0 means write. A mismatching select byte is not acknowledged.
- R2: For every byte the block accepts, it pulls SDA low during the 9th SCL clock. It changes its SDA drive only while SCL is low.
- R3: A byte write stores the data byte at the given word address. The sequence is: select byte with write, word address byte, data byte, Stop.
- R4: A page write accepts several data bytes. After each byte, only the low 4 address bits increment, so the address wraps inside the 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones at the wrapped addresses.
- R5: A random read returns the byte at the addressed location, most significant bit first. The sequence is: select byte with write, word address, repeated Start, select byte with read.
- R6: A current-address read returns the location that follows the last byte read.
- R7: A sequential read returns successive locations for as long as the master acknowledges. The address wraps from 255 to 0. A NoAck from the master ends the read.
- R8: While wpIn is high, the word address byte is still acknowledged, but data bytes are not acknowledged and nothing is stored.
- R9: After a Stop commits at least one byte, the select byte is not acknowledged for PROG_CYCLES clocks. After that period it is acknowledged again. A write that stores nothing starts no lockout.
- R10: While porActive is high, the block ignores the bus and never pulls SDA low.
- R11: Data is committed only at Stop. A repeated Start after data bytes throws the buffered bytes away.
- R12: After reset, SDA is not driven and every memory location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| porActive | input | 1 | Power-on reset in progress; bus ignored |
| chipSel | input | 3 | Strapped chip-enable pin values |
| wpIn | input | 1 | Write control; high blocks stores |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaDriveLow | output | 1 | High pulls the open-drain SDA line low |

## Verification
Some properties are checked on every cycle by the assertions:
- SDA drive changes only while the sampled SCL is low.
- No acknowledge is given during power-on reset.
- A select byte is never acknowledged while programming runs, and a data byte is never acknowledged with write control high.
- A page store never carries into the upper address bits, and every lockout starts from a commit.

Only the bench's scenarios can show that the data is right. These cover:
- values read back after byte and page writes, including the page wrap and the overflow;
- the 255-to-0 wrap of a sequential read;
- the continuation of a current-address read;
- data discarded on a repeated Start;
- the end of the lockout window.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W = 3;
  localparam logic [3:0] TYPE_CODE = 4'b1011;

  typedef enum logic [2:0] {P_IDLE, P_RX, P_ACK, P_TX, P_MACK} phase_t;
  typedef enum logic [1:0] {K_DEV, K_WADDR, K_WDATA} kind_t;

  typedef struct packed {
    logic shiftIn;
    logic setAddr;
    logic bufByte;
    logic commit;
    logic dropBuf;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } dpStrobes_t;
endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_slave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic              rxBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              progBusy
);
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int PAGES = 1 << (ADDR_W - PAGE_W);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0] mem [PAGES*PAGE_LEN];
  logic [BYTE_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] validMask;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] txReg;
  logic [CNT_W-1:0] progCnt;
  logic commitNow;

  assign commitNow = stb.commit && (|validMask);
  assign progBusy = (progCnt != '0);
  assign txMsb = txReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg <= '0;
      addrQ <= '0;
      validMask <= '0;
      progCnt <= '0;
      for (int j = 0; j < PAGE_LEN; j++) pageBuf[j] <= '0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], rxBit};
      if (stb.loadTx) txReg <= mem[addrQ];
      else if (stb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (stb.setAddr) addrQ <= ADDR_W'(rxByte);
      else if (stb.bufByte) addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + 1'b1;
      else if (stb.incAddr) addrQ <= addrQ + 1'b1;
      if (stb.bufByte) begin
        pageBuf[addrQ[PAGE_W-1:0]] <= rxByte;
        validMask[addrQ[PAGE_W-1:0]] <= 1'b1;
      end else if (stb.dropBuf || commitNow) begin
        validMask <= '0;
      end
      if (commitNow) progCnt <= CNT_W'(PROG_CYCLES);
      else if (progBusy) progCnt <= progCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAGES * PAGE_LEN; i++) mem[i] <= '0;
    end else if (commitNow) begin
      for (int p = 0; p < PAGES; p++)
        for (int j = 0; j < PAGE_LEN; j++)
          if (p == int'(addrQ[ADDR_W-1:PAGE_W]) && validMask[j])
            mem[p*PAGE_LEN+j] <= pageBuf[j];
    end
  end

  // R4
  page_bits_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufByte |=> $stable(addrQ[ADDR_W-1:PAGE_W]));

  // R9
  lockout_from_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && !$past(progBusy)) |-> $past(stb.commit));
endmodule

// File: rtl/eeprom_control.sv
module eeprom_control
  import eeprom_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porActive,
  input  logic [PIN_W-1:0]  chipSel,
  input  logic              wpIn,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              progBusy,
  output dpStrobes_t        stb,
  output logic              rxBit,
  output logic              sdaDriveLow
);
  logic sclR1, sclS, sclP, sdaR1, sdaS, sdaP;
  logic sclRise, sclFall, startDet, stopDet;
  phase_t phase;
  kind_t kind;
  logic [3:0] bitCnt;
  logic ackDrive, isRead, masterAck;
  logic devMatch;

  assign sclRise = sclS && !sclP;
  assign sclFall = !sclS && sclP;
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet = sclS && sclP && !sdaP && sdaS;
  assign rxBit = sdaS;
  assign devMatch = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == chipSel);
  assign sdaDriveLow = ackDrive || (phase == P_TX && !txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclR1, sclS, sclP, sdaR1, sdaS, sdaP} <= '1;
      phase <= P_IDLE;
      kind <= K_DEV;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      isRead <= 1'b0;
      masterAck <= 1'b0;
      stb <= '0;
    end else begin
      sclR1 <= sclIn;
      sclS <= sclR1;
      sclP <= sclS;
      sdaR1 <= sdaIn;
      sdaS <= sdaR1;
      sdaP <= sdaS;
      stb <= '0;
      if (porActive) begin
        phase <= P_IDLE;
        ackDrive <= 1'b0;
        stb.dropBuf <= 1'b1;
      end else if (startDet) begin
        phase <= P_RX;
        kind <= K_DEV;
        bitCnt <= '0;
        ackDrive <= 1'b0;
        stb.dropBuf <= 1'b1;
      end else if (stopDet) begin
        phase <= P_IDLE;
        ackDrive <= 1'b0;
        stb.commit <= 1'b1;
      end else begin
        unique case (phase)
          P_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              stb.shiftIn <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              unique case (kind)
                K_DEV: begin
                  if (devMatch && !progBusy) begin
                    ackDrive <= 1'b1;
                    isRead <= rxByte[0];
                    phase <= P_ACK;
                  end else phase <= P_IDLE;
                end
                K_WADDR: begin
                  stb.setAddr <= 1'b1;
                  ackDrive <= 1'b1;
                  phase <= P_ACK;
                end
                default: begin
                  if (!wpIn) begin
                    stb.bufByte <= 1'b1;
                    ackDrive <= 1'b1;
                    phase <= P_ACK;
                  end else phase <= P_IDLE;
                end
              endcase
            end
          end
          P_ACK: begin
            if (sclFall) begin
              ackDrive <= 1'b0;
              bitCnt <= '0;
              if (kind == K_DEV && isRead) begin
                stb.loadTx <= 1'b1;
                phase <= P_TX;
              end else begin
                phase <= P_RX;
                if (kind == K_DEV) kind <= K_WADDR;
                else kind <= K_WDATA;
              end
            end
          end
          P_TX: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                stb.incAddr <= 1'b1;
                phase <= P_MACK;
              end else stb.shiftTx <= 1'b1;
            end
          end
          P_MACK: begin
            if (sclRise) masterAck <= !sdaS;
            else if (sclFall) begin
              bitCnt <= '0;
              if (masterAck) begin
                stb.loadTx <= 1'b1;
                phase <= P_TX;
              end else phase <= P_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  drive_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow) && !$past(porActive) &&
     !$past(startDet) && !$past(stopDet)) |-> !$past(sclS));

  // R10
  por_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    porActive |=> !sdaDriveLow);

  // R9
  busy_no_select_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && !$past(ackDrive) && kind == K_DEV) |-> !$past(progBusy));

  // R8
  wp_no_data_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && !$past(ackDrive) && kind == K_WDATA) |-> !$past(wpIn));

  // R2
  no_ack_while_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_TX) |-> !ackDrive);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_slave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porActive,
  input  logic [PIN_W-1:0] chipSel,
  input  logic             wpIn,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow
);
  dpStrobes_t stb;
  logic rxBit, txMsb, progBusy;
  logic [BYTE_W-1:0] rxByte;

  eeprom_control ctrl (
    .clk(clk), .rstN(rstN), .porActive(porActive), .chipSel(chipSel),
    .wpIn(wpIn), .sclIn(sclIn), .sdaIn(sdaIn), .rxByte(rxByte),
    .txMsb(txMsb), .progBusy(progBusy), .stb(stb), .rxBit(rxBit),
    .sdaDriveLow(sdaDriveLow)
  );

  eeprom_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxBit(rxBit),
    .rxByte(rxByte), .txMsb(txMsb), .progBusy(progBusy)
  );
endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int PROG = 1000;
  localparam int Q = 10;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1011, PINS, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1011, PINS, 1'b1};

  logic clk = 0, rstN = 0, por = 0, wp = 0, sclM = 1, sdaM = 1;
  logic drv, sdaBus;
  int tests = 0, fails = 0;
  logic [7:0] rd [16];
  logic ack;

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~drv;

  serial_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rstN(rstN), .porActive(por), .chipSel(PINS), .wpIn(wp),
    .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(drv)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ(2);
  endtask

  task automatic bitC(input logic b, output logic s);
    sdaM = b; waitQ(); sclM = 1; waitQ(); s = sdaBus; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic wrByte(input logic [7:0] b, output logic a);
    logic s;
    for (int i = 7; i >= 0; i--) bitC(b[i], s);
    bitC(1'b1, s);
    a = !s;
  endtask

  task automatic rdByte(input logic mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitC(1'b1, s);
      d[i] = s;
    end
    bitC(!mAck, s);
  endtask

  task automatic writeSeq(input logic [7:0] a, input int n, input logic [7:0] first,
                          input logic [7:0] step, input string tag);
    startC();
    wrByte(DEV_W, ack); check(ack, {tag, " select"}, ack, 1);
    wrByte(a, ack); check(ack, {tag, " address"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      wrByte(8'(first + k * step), ack);
      check(ack, {tag, " data ack"}, ack, 1);
    end
    stopC();
    waitQ(PROG / Q + 20);
  endtask

  task automatic readAt(input logic [7:0] a, input int n, input string tag);
    startC();
    wrByte(DEV_W, ack); check(ack, {tag, " select"}, ack, 1);
    wrByte(a, ack); check(ack, {tag, " address"}, ack, 1);
    startC();
    wrByte(DEV_R, ack); check(ack, {tag, " read select"}, ack, 1);
    for (int k = 0; k < n; k++) rdByte(k != n - 1, rd[k]);
    stopC();
  endtask

  task automatic readCur(input string tag);
    startC();
    wrByte(DEV_R, ack); check(ack, {tag, " read select"}, ack, 1);
    rdByte(1'b0, rd[0]);
    stopC();
  endtask

  task automatic t_reset();
    check(!drv, "R12 sda idle", drv, 0);
    readAt(8'h77, 1, "R12");
    check(rd[0] == 8'h00, "R12 memory zero", rd[0], 0);
  endtask

  task automatic t_select();
    startC(); wrByte({4'b1011, 3'b011, 1'b0}, ack); stopC();
    check(!ack, "R1 wrong pins", ack, 0);
    startC(); wrByte({4'b1010, PINS, 1'b0}, ack); stopC();
    check(!ack, "R1 wrong type", ack, 0);
    startC(); wrByte(DEV_W, ack); stopC();
    check(ack, "R1 match", ack, 1);
  endtask

  task automatic t_byteWrite();
    startC();
    wrByte(DEV_W, ack); check(ack, "R2 select ack", ack, 1);
    wrByte(8'h10, ack); check(ack, "R3 address ack", ack, 1);
    wrByte(8'hA5, ack); check(ack, "R3 data ack", ack, 1);
    wrByte(8'h3C, ack); check(ack, "R4 second data ack", ack, 1);
    stopC();
    startC(); wrByte(DEV_W, ack); stopC();
    check(!ack, "R9 busy select nack", ack, 0);
    waitQ(PROG / Q + 20);
    startC(); wrByte(DEV_W, ack); stopC();
    check(ack, "R9 select after lockout", ack, 1);
    readAt(8'h10, 1, "R5");
    check(rd[0] == 8'hA5, "R3 R5 byte read", rd[0], 8'hA5);
    readCur("R6");
    check(rd[0] == 8'h3C, "R6 current address", rd[0], 8'h3C);
  endtask

  task automatic t_pageWrap();
    writeSeq(8'h3E, 4, 8'h11, 8'h11, "R4 wrap");
    readAt(8'h3E, 2, "R4");
    check(rd[0] == 8'h11, "R4 at 3E", rd[0], 8'h11);
    check(rd[1] == 8'h22, "R4 at 3F", rd[1], 8'h22);
    readAt(8'h30, 2, "R4");
    check(rd[0] == 8'h33, "R4 wrapped to 30", rd[0], 8'h33);
    check(rd[1] == 8'h44, "R4 wrapped to 31", rd[1], 8'h44);
    readAt(8'h40, 1, "R4");
    check(rd[0] == 8'h00, "R4 no spill to 40", rd[0], 0);
  endtask

  task automatic t_pageOver();
    writeSeq(8'h50, 17, 8'h80, 8'h01, "R4 over");
    readAt(8'h50, 2, "R4");
    check(rd[0] == 8'h90, "R4 overwrite 50", rd[0], 8'h90);
    check(rd[1] == 8'h81, "R4 keep 51", rd[1], 8'h81);
    readAt(8'h5F, 1, "R4");
    check(rd[0] == 8'h8F, "R4 last in page", rd[0], 8'h8F);
  endtask

  task automatic t_seqWrap();
    writeSeq(8'hFF, 1, 8'h5A, 8'h00, "R7");
    writeSeq(8'h00, 1, 8'hC3, 8'h00, "R7");
    readAt(8'hFE, 3, "R7");
    check(rd[0] == 8'h00, "R7 at FE", rd[0], 0);
    check(rd[1] == 8'h5A, "R7 at FF", rd[1], 8'h5A);
    check(rd[2] == 8'hC3, "R7 wrap to 00", rd[2], 8'hC3);
  endtask

  task automatic t_wp();
    wp = 1;
    startC();
    wrByte(DEV_W, ack); check(ack, "R8 select ack", ack, 1);
    wrByte(8'h20, ack); check(ack, "R8 address ack", ack, 1);
    wrByte(8'h77, ack); check(!ack, "R8 data nack", ack, 0);
    stopC();
    wp = 0;
    startC(); wrByte(DEV_W, ack); stopC();
    check(ack, "R9 no lockout without store", ack, 1);
    readAt(8'h20, 1, "R8");
    check(rd[0] == 8'h00, "R8 nothing stored", rd[0], 0);
  endtask

  task automatic t_restart();
    startC();
    wrByte(DEV_W, ack); wrByte(8'h21, ack); wrByte(8'h99, ack);
    check(ack, "R11 data ack", ack, 1);
    startC();
    wrByte(DEV_R, ack); check(ack, "R11 no lockout", ack, 1);
    rdByte(1'b0, rd[0]);
    stopC();
    readAt(8'h21, 1, "R11");
    check(rd[0] == 8'h00, "R11 discarded on restart", rd[0], 0);
  endtask

  task automatic t_por();
    por = 1;
    waitQ();
    startC(); wrByte(DEV_W, ack); stopC();
    check(!ack, "R10 por nack", ack, 0);
    check(!drv, "R10 por idle drive", drv, 0);
    por = 0;
    waitQ();
    startC(); wrByte(DEV_W, ack); stopC();
    check(ack, "R10 ack after por", ack, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    waitQ(2);
    t_reset();
    t_select();
    t_byteWrite();
    t_pageWrap();
    t_pageOver();
    t_seqWrap();
    t_wp();
    t_restart();
    t_por();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule